// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block collects the interrupt causes of a multi-channel DMA engine. Each channel has two sticky flags: a completion flag, which the channel raises with a one-cycle pulse when its transfer finishes, and a fault flag, which the channel raises with a one-cycle pulse when it hits an error. Software reads both flag sets through two read-only status registers. It clears each set separately by writing ones to a matching clear register.

From the flags the block drives one combined interrupt line. It also drives a priority-encoded index that names the lowest-numbered channel with any flag set. Channel 0 has the highest priority, so a service routine can read the index and handle the most urgent channel first. The register port is a plain single-cycle write strobe with a two-bit address. Read data is combinational from the address.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, every completion and fault flag is 0, `irq` is 0 and `pend_valid` is 0.
- R2: A 1 on `done_pulse[i]` at a rising clock edge sets completion flag i. From that edge on, the flag reads as bit i of the register at address 0.
- R3: A 1 on `fault_pulse[i]` at a rising clock edge sets fault flag i. From that edge on, the flag reads as bit i of the register at address 1.
- R4: A write to address 2 clears each completion flag whose data bit is 1. Fault flags are left unchanged.
- R5: A write to address 3 clears each fault flag whose data bit is 1. Completion flags are left unchanged.
- R6: A data bit of 0 in a write to address 2 or 3 leaves the matching flag unchanged.
- R7: When a set pulse and a clearing write hit the same flag at the same edge, the flag ends up set.
- R8: A flag holds its value when it receives neither a set pulse nor a clearing write.
- R9: `irq` is 1 exactly when at least one flag of either kind is set. No masking is applied.
- R10: `pend_valid` is 1 exactly when some channel has either flag set. `pend_idx` then gives the lowest-numbered such channel, as an unsigned binary number.
- R11: Addresses 2 and 3 read as 0. Writes to addresses 0 and 1 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| done_pulse | input | 8 | Per-channel completion set pulses, bit i = channel i |
| fault_pulse | input | 8 | Per-channel error set pulses, bit i = channel i |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Register address: 0 completion status, 1 fault status, 2 completion clear, 3 fault clear |
| reg_wdata | input | 8 | Write data, bit i = channel i |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |
| pend_valid | output | 1 | Some channel has a flag set |
| pend_idx | output | 3 | Lowest-numbered channel with a flag set |

## Verification
A flag that is stuck, lost or cleared by the wrong register shows up directly in the status register of its own kind. It is visible one edge after the pulse or write that should have changed it. The same fault also reaches `irq`, `pend_valid` and `pend_idx` in the same cycle. A wrong index from the encoder is visible combinationally against the status read-back. The sweep drives every pattern of the eight completion bits, each paired with a derived fault pattern. Partial clears, collisions of a set with a clear, zero writes and writes to the read-only addresses follow each pattern, so every flag is observed after every kind of update.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  parameter int unsigned CH_COUNT = 8;

  typedef enum logic [1:0] {
    SEL_DONE_STAT  = 2'd0,
    SEL_FAULT_STAT = 2'd1,
    SEL_DONE_CLR   = 2'd2,
    SEL_FAULT_CLR  = 2'd3
  } reg_sel_e;

  // index of the lowest set bit of v (0 when v is zero)
  function automatic logic [4:0] lowest_one(input logic [31:0] v);
    logic [4:0] r;
    r = 5'd0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  // clear vector produced by a write to a given register
  function automatic logic [31:0] clear_of(input logic wr, input logic [1:0] addr,
                                           input logic [1:0] target, input logic [31:0] data);
    return (wr && addr == target) ? data : 32'd0;
  endfunction

endpackage

// File: rtl/dma_irq_flags.sv
module dma_irq_flags #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_o[g] <= 1'b0;
      else if (set_i[g])  flag_o[g] <= 1'b1;
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end
  end

  // R2 R3: a set pulse always leaves the flag at 1 (R7: even with a clear)
  p_set_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flag_o & $past(set_i)) == $past(set_i)));

  // R4 R5: a clear without a set leaves the flag at 0
  p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((flag_o & $past(clr_i & ~set_i)) == '0));

  // R8: bits with neither set nor clear keep their value
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (((flag_o ^ $past(flag_o)) & ~$past(set_i | clr_i)) == '0));

endmodule

// File: rtl/dma_irq_prio.sv
module dma_irq_prio #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  import dma_irq_pkg::*;

  logic [31:0] mask_wide;
  logic [4:0]  first;

  always_comb begin
    mask_wide = '0;
    mask_wide[N-1:0] = mask_i;
    first   = lowest_one(mask_wide);
    valid_o = |mask_i;
    idx_o   = first[IW-1:0];
  end

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int unsigned N  = dma_irq_pkg::CH_COUNT,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  done_pulse,
  input  logic [N-1:0]  fault_pulse,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [N-1:0]  reg_wdata,
  output logic [N-1:0]  reg_rdata,
  output logic          irq,
  output logic          pend_valid,
  output logic [IW-1:0] pend_idx
);
  import dma_irq_pkg::*;

  logic [N-1:0] done_flag, fault_flag;
  logic [N-1:0] done_clr, fault_clr;
  logic [N-1:0] any_flag;
  logic [N-1:0] below_idx;
  logic [31:0]  wdata_wide, done_clr_w, fault_clr_w;

  always_comb begin
    wdata_wide = '0;
    wdata_wide[N-1:0] = reg_wdata;
    done_clr_w  = clear_of(reg_wr, reg_addr, SEL_DONE_CLR,  wdata_wide);
    fault_clr_w = clear_of(reg_wr, reg_addr, SEL_FAULT_CLR, wdata_wide);
    done_clr  = done_clr_w[N-1:0];
    fault_clr = fault_clr_w[N-1:0];
  end

  dma_irq_flags #(.N(N)) u_done (
    .clk(clk), .rst_n(rst_n), .set_i(done_pulse), .clr_i(done_clr), .flag_o(done_flag)
  );

  dma_irq_flags #(.N(N)) u_fault (
    .clk(clk), .rst_n(rst_n), .set_i(fault_pulse), .clr_i(fault_clr), .flag_o(fault_flag)
  );

  assign any_flag = done_flag | fault_flag;

  dma_irq_prio #(.N(N), .IW(IW)) u_prio (
    .mask_i(any_flag), .valid_o(pend_valid), .idx_o(pend_idx)
  );

  assign irq = |{done_flag, fault_flag};

  always_comb begin
    case (reg_sel_e'(reg_addr))
      SEL_DONE_STAT:  reg_rdata = done_flag;
      SEL_FAULT_STAT: reg_rdata = fault_flag;
      default:        reg_rdata = '0;
    endcase
  end

  assign below_idx = (N'(1) << pend_idx) - N'(1);

  // R9: interrupt line agrees with the encoder's valid bit
  p_irq_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == pend_valid);

  // R10: the indexed channel is pending and no lower channel is
  p_idx_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> (any_flag[pend_idx] && ((any_flag & below_idx) == '0)));

  // R11: status-address writes change nothing
  p_ro_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr[1] && done_pulse == '0 && fault_pulse == '0)
      |=> ($stable(done_flag) && $stable(fault_flag)));

endmodule

// File: tb/sim_dma_irq_status.sv
module sim_dma_irq_status;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] done_pulse = '0, fault_pulse = '0, reg_wdata = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_rdata;
  logic       irq, pend_valid;
  logic [2:0] pend_idx;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [7:0] m_done = '0, m_fault = '0;

  always #4 clk = ~clk;

  dma_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .fault_pulse(fault_pulse),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .pend_valid(pend_valid), .pend_idx(pend_idx)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [7:0] any;
    int low;
    any = m_done | m_fault;
    low = 0;
    while (low < 8 && !any[low]) low++;
    reg_addr = 2'd0; #1; chk(req, "done status", reg_rdata, m_done);
    reg_addr = 2'd1; #1; chk(req, "fault status", reg_rdata, m_fault);
    reg_addr = 2'd2; #1; chk("R11", "done clr readback", reg_rdata, 0);
    reg_addr = 2'd3; #1; chk("R11", "fault clr readback", reg_rdata, 0);
    chk("R9", "irq", irq, (any != 0));
    chk("R10", "pend_valid", pend_valid, (any != 0));
    if (any != 0) chk("R10", "pend_idx", pend_idx, low);
  endtask

  task automatic cyc(input logic [7:0] ds, input logic [7:0] fs, input logic wr,
                     input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    done_pulse = ds; fault_pulse = fs; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    m_done  = ds | (m_done  & ~((wr && a == 2'd2) ? d : 8'h00));
    m_fault = fs | (m_fault & ~((wr && a == 2'd3) ? d : 8'h00));
    @(negedge clk);
    done_pulse = '0; fault_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    for (int p = 0; p < 256; p++) begin
      logic [7:0] q;
      q = {p[2:0], p[7:3]} ^ 8'hC3;
      cyc(8'(p), q, 1'b0, 2'd0, 8'h00);
      check_all("R2"); check_all("R3");
      cyc(8'h00, 8'h00, 1'b1, 2'd2, 8'(p) ^ 8'h0F);
      check_all("R4");
      cyc(8'h00, 8'h00, 1'b1, 2'd3, q ^ 8'hA5);
      check_all("R5");
      cyc(8'(p) & 8'h99, q & 8'h66, 1'b1, 2'd2, 8'hFF);
      check_all("R7");
      cyc(8'h00, 8'h00, 1'b1, 2'd2, 8'h00);
      check_all("R6");
      cyc(8'h00, 8'h00, 1'b1, 2'd3, 8'h00);
      check_all("R6");
      cyc(8'h00, 8'h00, 1'b1, 2'(p & 1), 8'hFF);
      check_all("R11");
      cyc(8'h00, 8'h00, 1'b0, 2'd2, 8'hFF);
      check_all("R8");
      cyc(8'h00, 8'h00, 1'b1, 2'd2, 8'hFF);
      cyc(8'h00, 8'h00, 1'b1, 2'd3, 8'hFF);
      check_all("R9");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule